// File: doc/BRIEF.md
# Receive Buffer Descriptor Ring Controller

This block sits behind a transparent serial receiver and moves the received byte stream into memory buffers. Each buffer is described by an 8-byte descriptor in a local dual-port memory. The descriptor holds a 16-bit status/control word at offset 0, a 16-bit data length at offset 2 and a 32-bit buffer pointer at offset 4. The upper pointer half is at offset 4 and the lower half at offset 6. The descriptors form a ring. The ring has no length register. It ends at the descriptor whose wrap bit is set, and the controller then returns to the ring base.

Software marks a descriptor as free by setting its empty bit. When a byte arrives and no buffer is open, the controller reads the descriptor at its current position. If the descriptor is free, the controller reads the pointer and stores bytes until the buffer is full, a receive error is flagged, a close command arrives or a hunt command arrives. It then writes the length, then the status with the empty bit cleared, and latches a close event that can raise a maskable interrupt. If the current descriptor is not free, the byte is dropped and a busy event is latched. The same descriptor is polled again on the next byte.

The memory port is a 16-bit synchronous port with byte enables and one cycle of read latency. The receiver pushes one byte per strobe and cannot be stalled.

Top module: `rxbd_ring_ctrl`

## Requirements
- R1: After reset, evt_o and irq_o are 0 and no memory request is made while no byte arrives.
- R2: A byte arriving with no buffer open triggers a read of the status word at the current descriptor. If its empty bit (bit 15) is 1, the pointer words at +4 (upper) and +6 (lower) are read. The n-th byte of the buffer is then written to pointer+n, using lane [15:8] for even addresses and lane [7:0] for odd addresses, with only that lane enabled.
- R3: When the byte count reaches max_len_i, the buffer closes. The length word goes to +2 and, on the next cycle, the status word goes to +0 with bit 15 (empty) and bit 14 cleared and the other bits kept.
- R4: A pulse on cmd_close_i closes the open buffer. The written length is the number of bytes stored, and the status gains no error bits.
- R5: A pulse on rx_err_i closes the open buffer. The written status additionally has bit 11 (last) and bit 3 (receive error) set.
- R6: After closing a descriptor whose bit 13 (wrap) is 1, the next descriptor is at the ring base. Otherwise it is 8 bytes further on. The ring base is a multiple of 8.
- R7: A byte that arrives while the current descriptor has bit 15 at 0 is not stored, and event bit 1 (busy) is set. The next byte reads the same descriptor again.
- R8: Closing a descriptor with bit 12 (interrupt) set sets event bit 0. Event bits stay set until a 1 is written to the same bit of evt_clr_i. irq_o is 1 exactly when some event bit is set together with its int_mask_i bit.
- R9: A pulse on cmd_hunt_i reloads the ring base from ring_base_i and closes the open buffer. The next buffer then uses the descriptor at the new base.
- R10: A byte that arrives while the previous byte is still held (rx_ready_o low) is dropped. If a buffer is open, bit 2 (overrun) is set in its written status.
- R11: While rx_en_i is 0, rx_ready_o is 0 and bytes are ignored. A rising edge of rx_en_i loads the ring base from ring_base_i as the current descriptor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_en_i | input | 1 | Receiver enable; a rising edge loads the ring base |
| ring_base_i | input | AW | Byte address of the first descriptor |
| max_len_i | input | LW | Buffer size in bytes |
| int_mask_i | input | 2 | Interrupt mask per event bit |
| evt_clr_i | input | 2 | Write-1-to-clear for the event bits |
| evt_o | output | 2 | Event bits: 0 close, 1 busy |
| irq_o | output | 1 | Maskable interrupt request |
| rx_valid_i | input | 1 | Byte strobe from the receiver |
| rx_data_i | input | 8 | Received byte |
| rx_ready_o | output | 1 | Holding register free |
| rx_err_i | input | 1 | Receive error pulse |
| cmd_hunt_i | input | 1 | Enter-hunt command pulse |
| cmd_close_i | input | 1 | Close-buffer command pulse |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Write when 1, read when 0 |
| mem_addr_o | output | AW | Byte address |
| mem_be_o | output | 2 | Lane enables: bit 1 lane [15:8], bit 0 lane [7:0] |
| mem_wdata_o | output | 16 | Write data |
| mem_rdata_i | input | 16 | Read data, one cycle after the request |

## Verification
When a byte is strobed in cycle c into an already open buffer, it is written to memory in cycle c+1. If a descriptor fetch is needed first, the byte is written in cycle c+5: one cycle to issue the status read and three cycles of reads. A command or error pulse in cycle c, or a fill to capacity, issues the length write two cycles later and the status write one cycle after that. The event bits change on the edge that ends the status write, and irq_o follows a mask change combinationally. The bench leaves at least eight cycles after every stimulus before it reads back the memory model or the event outputs. It samples on the falling edge.

// File: rtl/rxbd_pkg.sv
package rxbd_pkg;
  localparam int unsigned MEM_W     = 16;
  localparam int unsigned BYTE_W    = 8;
  localparam int unsigned PTR_W     = 32;
  localparam int unsigned DESC_SZ   = 8;
  localparam int unsigned EVT_W     = 2;

  localparam int unsigned OFS_LEN   = 2;
  localparam int unsigned OFS_PHI   = 4;
  localparam int unsigned OFS_PLO   = 6;

  localparam int unsigned ST_EMPTY  = 15;
  localparam int unsigned ST_RSVD   = 14;
  localparam int unsigned ST_WRAP   = 13;
  localparam int unsigned ST_INTR   = 12;
  localparam int unsigned ST_LAST   = 11;
  localparam int unsigned ST_RXERR  = 3;
  localparam int unsigned ST_OVRUN  = 2;

  localparam int unsigned EV_CLOSE  = 0;
  localparam int unsigned EV_BUSY   = 1;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_GET_ST,
    RX_GET_PHI,
    RX_GET_PLO,
    RX_OPEN,
    RX_PUT_LEN,
    RX_PUT_ST
  } rx_state_e;
endpackage

// File: rtl/rxbd_byte_hold.sv
module rxbd_byte_hold #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_i,
  input  logic          valid_i,
  input  logic [DW-1:0] data_i,
  input  logic          take_i,
  input  logic          drop_i,
  output logic          ready_o,
  output logic          hold_vld_o,
  output logic [DW-1:0] hold_data_o,
  output logic          ovr_o
);
  logic          vld_q, vld_n;
  logic [DW-1:0] dat_q, dat_n;
  logic          accept;

  assign ready_o     = en_i & ~vld_q;
  assign accept      = valid_i & ready_o;
  assign ovr_o       = valid_i & en_i & vld_q;
  assign hold_vld_o  = vld_q;
  assign hold_data_o = dat_q;

  always_comb begin
    vld_n = vld_q;
    dat_n = dat_q;
    if (take_i || drop_i) begin
      vld_n = 1'b0;
    end
    if (accept) begin
      vld_n = 1'b1;
      dat_n = data_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      dat_q <= '0;
    end else begin
      vld_q <= vld_n;
      if (accept) begin
        dat_q <= dat_n;
      end
    end
  end
endmodule

// File: rtl/rxbd_ring_ptr.sv
module rxbd_ring_ptr
  import rxbd_pkg::*;
#(
  parameter int unsigned AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_i,
  input  logic [AW-1:0] ring_base_i,
  input  logic          hunt_i,
  input  logic          busy_i,
  input  logic          advance_i,
  input  logic          to_base_i,
  output logic [AW-1:0] cur_addr_o
);
  logic          en_q;
  logic          load_start;
  logic [AW-1:0] base_q, base_n;
  logic [AW-1:0] cur_q, cur_n;

  assign load_start = en_i & ~en_q;
  assign cur_addr_o = cur_q;

  always_comb begin
    base_n = base_q;
    cur_n  = cur_q;
    if (load_start || hunt_i) begin
      base_n = ring_base_i;
    end
    if (load_start || (hunt_i && !busy_i)) begin
      cur_n = ring_base_i;
    end else if (advance_i) begin
      cur_n = to_base_i ? base_q : (cur_q + AW'(DESC_SZ));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      base_q <= '0;
      cur_q  <= '0;
    end else begin
      en_q   <= en_i;
      base_q <= base_n;
      cur_q  <= cur_n;
    end
  end
endmodule

// File: rtl/rxbd_evt.sv
module rxbd_evt #(
  parameter int unsigned EW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [EW-1:0] set_i,
  input  logic [EW-1:0] clr_i,
  input  logic [EW-1:0] mask_i,
  output logic [EW-1:0] evt_o,
  output logic          irq_o
);
  logic [EW-1:0] evt_q, evt_n;

  always_comb begin
    for (int i = 0; i < int'(EW); i++) begin
      evt_n[i] = set_i[i] | (evt_q[i] & ~clr_i[i]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_q <= '0;
    end else begin
      evt_q <= evt_n;
    end
  end

  assign evt_o = evt_q;
  assign irq_o = |(evt_q & mask_i);
endmodule

// File: rtl/rxbd_rx_fsm.sv
module rxbd_rx_fsm
  import rxbd_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter int unsigned LW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic [LW-1:0]     max_len_i,
  input  logic              hold_vld_i,
  input  logic [BYTE_W-1:0] hold_data_i,
  input  logic              ovr_i,
  input  logic              err_i,
  input  logic              hunt_i,
  input  logic              close_i,
  input  logic [AW-1:0]     cur_addr_i,
  input  logic [MEM_W-1:0]  mem_rdata_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [AW-1:0]     mem_addr_o,
  output logic [1:0]        mem_be_o,
  output logic [MEM_W-1:0]  mem_wdata_o,
  output logic              take_o,
  output logic              drop_o,
  output logic              advance_o,
  output logic              to_base_o,
  output logic              busy_o,
  output logic [EVT_W-1:0]  evt_set_o
);
  rx_state_e          state_q, state_n;
  logic [MEM_W-1:0]   status_q, status_n;
  logic [PTR_W-1:0]   ptr_q, ptr_n;
  logic [LW-1:0]      cnt_q, cnt_n;
  logic               p_err_q, p_err_n;
  logic               p_hunt_q, p_hunt_n;
  logic               p_close_q, p_close_n;
  logic               ov_q, ov_n;
  logic               open_st;
  logic               any_pend;
  logic [LW-1:0]      cnt_inc;
  logic [AW-1:0]      byte_addr;
  logic [MEM_W-1:0]   wb_status;

  assign open_st   = (state_q == RX_GET_ST) || (state_q == RX_GET_PHI) ||
                     (state_q == RX_GET_PLO) || (state_q == RX_OPEN);
  assign any_pend  = p_err_q | p_hunt_q | p_close_q;
  assign cnt_inc   = cnt_q + LW'(1);
  assign byte_addr = ptr_q[AW-1:0] + AW'(cnt_q);
  assign busy_o    = (state_q != RX_IDLE);

  always_comb begin
    wb_status            = status_q;
    wb_status[ST_EMPTY]  = 1'b0;
    wb_status[ST_RSVD]   = 1'b0;
    if (p_err_q) begin
      wb_status[ST_LAST]  = 1'b1;
      wb_status[ST_RXERR] = 1'b1;
    end
    if (ov_q) begin
      wb_status[ST_OVRUN] = 1'b1;
    end
  end

  always_comb begin
    state_n   = state_q;
    status_n  = status_q;
    ptr_n     = ptr_q;
    cnt_n     = cnt_q;
    p_err_n   = p_err_q   | (open_st & err_i);
    p_hunt_n  = p_hunt_q  | (open_st & hunt_i);
    p_close_n = p_close_q | (open_st & close_i);
    ov_n      = ov_q      | (open_st & ovr_i);

    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = cur_addr_i;
    mem_be_o    = 2'b11;
    mem_wdata_o = '0;
    take_o      = 1'b0;
    drop_o      = 1'b0;
    advance_o   = 1'b0;
    to_base_o   = 1'b0;
    evt_set_o   = '0;

    unique case (state_q)
      RX_IDLE: begin
        if (hold_vld_i && en_i) begin
          mem_req_o = 1'b1;
          state_n   = RX_GET_ST;
          p_err_n   = 1'b0;
          p_hunt_n  = 1'b0;
          p_close_n = 1'b0;
          ov_n      = 1'b0;
        end
      end
      RX_GET_ST: begin
        status_n = mem_rdata_i;
        if (!mem_rdata_i[ST_EMPTY]) begin
          drop_o             = 1'b1;
          evt_set_o[EV_BUSY] = 1'b1;
          p_err_n            = 1'b0;
          p_hunt_n           = 1'b0;
          p_close_n          = 1'b0;
          ov_n               = 1'b0;
          state_n            = RX_IDLE;
        end else begin
          mem_req_o  = 1'b1;
          mem_addr_o = cur_addr_i + AW'(OFS_PHI);
          state_n    = RX_GET_PHI;
        end
      end
      RX_GET_PHI: begin
        ptr_n[PTR_W-1:MEM_W] = mem_rdata_i;
        mem_req_o            = 1'b1;
        mem_addr_o           = cur_addr_i + AW'(OFS_PLO);
        state_n              = RX_GET_PLO;
      end
      RX_GET_PLO: begin
        ptr_n[MEM_W-1:0] = mem_rdata_i;
        cnt_n            = '0;
        state_n          = RX_OPEN;
      end
      RX_OPEN: begin
        if (any_pend) begin
          state_n = RX_PUT_LEN;
        end else if (hold_vld_i) begin
          mem_req_o   = 1'b1;
          mem_we_o    = 1'b1;
          mem_addr_o  = byte_addr;
          mem_be_o    = byte_addr[0] ? 2'b01 : 2'b10;
          mem_wdata_o = {hold_data_i, hold_data_i};
          take_o      = 1'b1;
          cnt_n       = cnt_inc;
          if (cnt_inc == max_len_i) begin
            state_n = RX_PUT_LEN;
          end
        end
      end
      RX_PUT_LEN: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = cur_addr_i + AW'(OFS_LEN);
        mem_wdata_o = MEM_W'(cnt_q);
        state_n     = RX_PUT_ST;
      end
      RX_PUT_ST: begin
        mem_req_o           = 1'b1;
        mem_we_o            = 1'b1;
        mem_wdata_o         = wb_status;
        advance_o           = 1'b1;
        to_base_o           = status_q[ST_WRAP] | p_hunt_q;
        evt_set_o[EV_CLOSE] = status_q[ST_INTR];
        state_n             = RX_IDLE;
      end
      default: begin
        state_n = RX_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= RX_IDLE;
      status_q  <= '0;
      ptr_q     <= '0;
      cnt_q     <= '0;
      p_err_q   <= 1'b0;
      p_hunt_q  <= 1'b0;
      p_close_q <= 1'b0;
      ov_q      <= 1'b0;
    end else begin
      state_q   <= state_n;
      status_q  <= status_n;
      ptr_q     <= ptr_n;
      cnt_q     <= cnt_n;
      p_err_q   <= p_err_n;
      p_hunt_q  <= p_hunt_n;
      p_close_q <= p_close_n;
      ov_q      <= ov_n;
    end
  end
endmodule

// File: rtl/rxbd_ring_ctrl.sv
module rxbd_ring_ctrl
  import rxbd_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter int unsigned LW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_en_i,
  input  logic [AW-1:0]     ring_base_i,
  input  logic [LW-1:0]     max_len_i,
  input  logic [1:0]        int_mask_i,
  input  logic [1:0]        evt_clr_i,
  output logic [1:0]        evt_o,
  output logic              irq_o,
  input  logic              rx_valid_i,
  input  logic [7:0]        rx_data_i,
  output logic              rx_ready_o,
  input  logic              rx_err_i,
  input  logic              cmd_hunt_i,
  input  logic              cmd_close_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [AW-1:0]     mem_addr_o,
  output logic [1:0]        mem_be_o,
  output logic [15:0]       mem_wdata_o,
  input  logic [15:0]       mem_rdata_i
);
  logic              rs_q1, rs_q2;
  logic              rst_int_n;
  logic              hold_vld;
  logic [BYTE_W-1:0] hold_data;
  logic              ovr;
  logic              take;
  logic              drop;
  logic              advance;
  logic              to_base;
  logic              busy;
  logic [AW-1:0]     cur_addr;
  logic [EVT_W-1:0]  evt_set;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_q1 <= 1'b0;
      rs_q2 <= 1'b0;
    end else begin
      rs_q1 <= 1'b1;
      rs_q2 <= rs_q1;
    end
  end
  assign rst_int_n = rs_q2;

  rxbd_byte_hold #(.DW(BYTE_W)) u_hold (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .en_i        (rx_en_i),
    .valid_i     (rx_valid_i),
    .data_i      (rx_data_i),
    .take_i      (take),
    .drop_i      (drop),
    .ready_o     (rx_ready_o),
    .hold_vld_o  (hold_vld),
    .hold_data_o (hold_data),
    .ovr_o       (ovr)
  );

  rxbd_ring_ptr #(.AW(AW)) u_ring (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .en_i        (rx_en_i),
    .ring_base_i (ring_base_i),
    .hunt_i      (cmd_hunt_i),
    .busy_i      (busy),
    .advance_i   (advance),
    .to_base_i   (to_base),
    .cur_addr_o  (cur_addr)
  );

  rxbd_rx_fsm #(.AW(AW), .LW(LW)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .en_i        (rx_en_i),
    .max_len_i   (max_len_i),
    .hold_vld_i  (hold_vld),
    .hold_data_i (hold_data),
    .ovr_i       (ovr),
    .err_i       (rx_err_i),
    .hunt_i      (cmd_hunt_i),
    .close_i     (cmd_close_i),
    .cur_addr_i  (cur_addr),
    .mem_rdata_i (mem_rdata_i),
    .mem_req_o   (mem_req_o),
    .mem_we_o    (mem_we_o),
    .mem_addr_o  (mem_addr_o),
    .mem_be_o    (mem_be_o),
    .mem_wdata_o (mem_wdata_o),
    .take_o      (take),
    .drop_o      (drop),
    .advance_o   (advance),
    .to_base_o   (to_base),
    .busy_o      (busy),
    .evt_set_o   (evt_set)
  );

  rxbd_evt #(.EW(EVT_W)) u_evt (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .set_i  (evt_set),
    .clr_i  (evt_clr_i),
    .mask_i (int_mask_i),
    .evt_o  (evt_o),
    .irq_o  (irq_o)
  );
endmodule

// File: rtl/rxbd_ring_ctrl_chk.sv
module rxbd_ring_ctrl_chk #(
  parameter int unsigned AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rx_en_i,
  input logic          rx_ready_o,
  input logic [1:0]    int_mask_i,
  input logic [1:0]    evt_clr_i,
  input logic [1:0]    evt_o,
  input logic          irq_o,
  input logic          mem_req_o,
  input logic          mem_we_o,
  input logic [AW-1:0] mem_addr_o,
  input logic [1:0]    mem_be_o,
  input logic [15:0]   mem_wdata_o
);
  // R3: a full-word write at a descriptor's status slot never leaves it owned
  p_status_released_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && mem_we_o && mem_be_o == 2'b11 && mem_addr_o[2:1] == 2'b00)
      |-> (!mem_wdata_o[15] && !mem_wdata_o[14]));

  // R3: the length write is followed at once by the status write of the same descriptor
  p_len_then_status_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && mem_we_o && mem_be_o == 2'b11 && mem_addr_o[2:1] == 2'b01)
      |=> (mem_req_o && mem_we_o && mem_be_o == 2'b11 &&
           mem_addr_o == AW'($past(mem_addr_o) - AW'(2))));

  // R2: a data byte uses exactly one lane, picked by the address parity
  p_byte_lane_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && mem_we_o && mem_be_o != 2'b11)
      |-> ($countones(mem_be_o) == 1 && mem_be_o[1] == !mem_addr_o[0] &&
           mem_wdata_o[15:8] == mem_wdata_o[7:0]));

  // R8: a set event bit survives until cleared
  p_evt_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_o[0] && !evt_clr_i[0]) |=> evt_o[0]);

  // R8: no interrupt without an enabled mask bit
  p_irq_masked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (int_mask_i != 2'b00));

  // R11: no byte is accepted while the receiver is disabled
  p_ready_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en_i |-> !rx_ready_o);
endmodule

bind rxbd_ring_ctrl rxbd_ring_ctrl_chk #(.AW(AW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .rx_en_i     (rx_en_i),
  .rx_ready_o  (rx_ready_o),
  .int_mask_i  (int_mask_i),
  .evt_clr_i   (evt_clr_i),
  .evt_o       (evt_o),
  .irq_o       (irq_o),
  .mem_req_o   (mem_req_o),
  .mem_we_o    (mem_we_o),
  .mem_addr_o  (mem_addr_o),
  .mem_be_o    (mem_be_o),
  .mem_wdata_o (mem_wdata_o)
);

// File: tb/rxbd_ring_ctrl_tb.sv
module rxbd_ring_ctrl_tb;
  localparam int AW = 16;
  localparam int LW = 16;

  logic          clk;
  logic          rst_n;
  logic          rx_en_i;
  logic [AW-1:0] ring_base_i;
  logic [LW-1:0] max_len_i;
  logic [1:0]    int_mask_i;
  logic [1:0]    evt_clr_i;
  logic [1:0]    evt_o;
  logic          irq_o;
  logic          rx_valid_i;
  logic [7:0]    rx_data_i;
  logic          rx_ready_o;
  logic          rx_err_i;
  logic          cmd_hunt_i;
  logic          cmd_close_i;
  logic          mem_req_o;
  logic          mem_we_o;
  logic [AW-1:0] mem_addr_o;
  logic [1:0]    mem_be_o;
  logic [15:0]   mem_wdata_o;
  logic [15:0]   mem_rdata_i;

  logic [15:0]   mem [0:4095];
  int            checks;
  int            errors;
  int            req_seen;

  rxbd_ring_ctrl #(.AW(AW), .LW(LW)) u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .rx_en_i     (rx_en_i),
    .ring_base_i (ring_base_i),
    .max_len_i   (max_len_i),
    .int_mask_i  (int_mask_i),
    .evt_clr_i   (evt_clr_i),
    .evt_o       (evt_o),
    .irq_o       (irq_o),
    .rx_valid_i  (rx_valid_i),
    .rx_data_i   (rx_data_i),
    .rx_ready_o  (rx_ready_o),
    .rx_err_i    (rx_err_i),
    .cmd_hunt_i  (cmd_hunt_i),
    .cmd_close_i (cmd_close_i),
    .mem_req_o   (mem_req_o),
    .mem_we_o    (mem_we_o),
    .mem_addr_o  (mem_addr_o),
    .mem_be_o    (mem_be_o),
    .mem_wdata_o (mem_wdata_o),
    .mem_rdata_i (mem_rdata_i)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(posedge clk) begin
    if (mem_req_o && !mem_we_o) begin
      mem_rdata_i <= mem[mem_addr_o[12:1]];
    end
    if (mem_req_o && mem_we_o) begin
      if (mem_be_o[1]) mem[mem_addr_o[12:1]][15:8] <= mem_wdata_o[15:8];
      if (mem_be_o[0]) mem[mem_addr_o[12:1]][7:0]  <= mem_wdata_o[7:0];
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] rd_byte(input int a);
    logic [15:0] w;
    w = mem[a / 2];
    return (a % 2 == 1) ? w[7:0] : w[15:8];
  endfunction

  function automatic logic [15:0] rd_word(input int a);
    return mem[a / 2];
  endfunction

  task automatic put_desc(input int a, input logic [15:0] st, input logic [31:0] ptr);
    mem[a / 2]     = st;
    mem[a / 2 + 1] = 16'h0000;
    mem[a / 2 + 2] = ptr[31:16];
    mem[a / 2 + 3] = ptr[15:0];
  endtask

  task automatic settle();
    repeat (8) @(negedge clk);
  endtask

  task automatic send_byte(input logic [7:0] d);
    @(negedge clk);
    rx_valid_i = 1'b1;
    rx_data_i  = d;
    @(negedge clk);
    rx_valid_i = 1'b0;
    settle();
  endtask

  task automatic pulse_close();
    @(negedge clk); cmd_close_i = 1'b1;
    @(negedge clk); cmd_close_i = 1'b0;
    settle();
  endtask

  task automatic pulse_err();
    @(negedge clk); rx_err_i = 1'b1;
    @(negedge clk); rx_err_i = 1'b0;
    settle();
  endtask

  task automatic pulse_hunt();
    @(negedge clk); cmd_hunt_i = 1'b1;
    @(negedge clk); cmd_hunt_i = 1'b0;
    settle();
  endtask

  task automatic clear_evt(input logic [1:0] bits);
    @(negedge clk); evt_clr_i = bits;
    @(negedge clk); evt_clr_i = 2'b00;
  endtask

  task automatic t_reset();
    req_seen = 0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (mem_req_o) req_seen++;
    end
    chk("R1 evt after reset", 32'(evt_o), 32'h0);
    chk("R1 irq after reset", 32'(irq_o), 32'h0);
    chk("R1 no memory request", 32'(req_seen), 32'h0);
  endtask

  task automatic t_full_and_irq();
    send_byte(8'hA0); send_byte(8'hA1); send_byte(8'hA2); send_byte(8'hA3);
    chk("R2 byte 0 at pointer", 32'(rd_byte('h1000)), 32'hA0);
    chk("R2 byte 3 at pointer+3", 32'(rd_byte('h1003)), 32'hA3);
    chk("R3 length on full", 32'(rd_word('h102)), 32'h4);
    chk("R3 status on full", 32'(rd_word('h100)), 32'h1000);
    chk("R8 close event latched", 32'(evt_o), 32'h1);
    chk("R8 irq masked off", 32'(irq_o), 32'h0);
    @(negedge clk); int_mask_i = 2'b01;
    @(negedge clk);
    chk("R8 irq with mask", 32'(irq_o), 32'h1);
    clear_evt(2'b01);
    @(negedge clk);
    chk("R8 event cleared", 32'(evt_o), 32'h0);
    chk("R8 irq after clear", 32'(irq_o), 32'h0);
  endtask

  task automatic t_close_cmd();
    send_byte(8'hB0); send_byte(8'hB1);
    pulse_close();
    chk("R4 bytes in second buffer", 32'({rd_byte('h1100), rd_byte('h1101)}), 32'hB0B1);
    chk("R4 length on close", 32'(rd_word('h10A)), 32'h2);
    chk("R4 status on close", 32'(rd_word('h108)), 32'h0000);
    chk("R8 no event without interrupt bit", 32'(evt_o), 32'h0);
  endtask

  task automatic t_error_wrap();
    send_byte(8'hC0);
    pulse_err();
    chk("R5 status on error", 32'(rd_word('h110)), 32'h3808);
    chk("R5 length on error", 32'(rd_word('h112)), 32'h1);
    chk("R8 irq on interrupting close", 32'(irq_o), 32'h1);
    clear_evt(2'b01);
    put_desc('h100, 16'h8000, 32'h0000_1300);
    send_byte(8'hD0);
    chk("R6 wrap returns to base", 32'(rd_byte('h1300)), 32'hD0);
    pulse_close();
    chk("R6 base descriptor closed", 32'(rd_word('h100)), 32'h0000);
  endtask

  task automatic t_not_empty();
    send_byte(8'h55);
    chk("R7 busy event", 32'(evt_o), 32'h2);
    chk("R7 descriptor untouched", 32'(rd_word('h108)), 32'h0000);
    chk("R7 byte not stored", 32'(rd_byte('h1102)), 32'h00);
    clear_evt(2'b10);
    put_desc('h108, 16'h8000, 32'h0000_1400);
    send_byte(8'h66);
    chk("R7 same descriptor polled again", 32'(rd_byte('h1400)), 32'h66);
  endtask

  task automatic t_hunt();
    put_desc('h180, 16'h8000, 32'h0000_1500);
    @(negedge clk); ring_base_i = 16'h0180;
    pulse_hunt();
    chk("R9 hunt closes buffer", 32'(rd_word('h108)), 32'h0000);
    chk("R9 hunt length", 32'(rd_word('h10A)), 32'h1);
    send_byte(8'h77);
    chk("R9 next buffer at new base", 32'(rd_byte('h1500)), 32'h77);
  endtask

  task automatic t_overrun();
    @(negedge clk); rx_valid_i = 1'b1; rx_data_i = 8'hE1;
    @(negedge clk); rx_data_i = 8'hE2;
    @(negedge clk); rx_valid_i = 1'b0;
    settle();
    pulse_close();
    chk("R10 first byte kept", 32'(rd_byte('h1501)), 32'hE1);
    chk("R10 second byte dropped", 32'(rd_byte('h1502)), 32'h00);
    chk("R10 overrun in status", 32'(rd_word('h180)), 32'h0004);
    chk("R10 length excludes dropped byte", 32'(rd_word('h182)), 32'h2);
  endtask

  task automatic t_enable();
    put_desc('h188, 16'h8000, 32'h0000_1600);
    @(negedge clk); rx_en_i = 1'b0;
    @(negedge clk);
    chk("R11 not ready while disabled", 32'(rx_ready_o), 32'h0);
    send_byte(8'h99);
    chk("R11 byte ignored while disabled", 32'(rd_byte('h1600)), 32'h00);
    chk("R11 descriptor untouched while disabled", 32'(rd_word('h188)), 32'h8000);
    put_desc('h1C0, 16'h8000, 32'h0000_1700);
    @(negedge clk); ring_base_i = 16'h01C0;
    @(negedge clk); rx_en_i = 1'b1;
    settle();
    send_byte(8'h44);
    chk("R11 enable loads new base", 32'(rd_byte('h1700)), 32'h44);
  endtask

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = 16'h0000;
    checks      = 0;
    errors      = 0;
    rst_n       = 1'b0;
    rx_en_i     = 1'b0;
    ring_base_i = 16'h0100;
    max_len_i   = 16'd4;
    int_mask_i  = 2'b00;
    evt_clr_i   = 2'b00;
    rx_valid_i  = 1'b0;
    rx_data_i   = 8'h00;
    rx_err_i    = 1'b0;
    cmd_hunt_i  = 1'b0;
    cmd_close_i = 1'b0;
    put_desc('h100, 16'h9000, 32'h0000_1000);
    put_desc('h108, 16'h8000, 32'h0000_1100);
    put_desc('h110, 16'hB000, 32'h0000_1200);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    rx_en_i = 1'b1;
    settle();
    t_full_and_irq();
    t_close_cmd();
    t_error_wrap();
    t_not_empty();
    t_hunt();
    t_overrun();
    t_enable();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule